// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block turns single bus-cycle requests from an upstream sequencer into correctly timed pin activity on an 8-bit NAND flash interface. Each request names one of four cycle kinds: command, address, data write or data read. The block then walks through three phases. The first is a latch-enable setup phase. The second is a strobe-active phase, in which the write or read strobe is held low. The third is a hold phase. The length of each phase comes from a programmable field counted in system clocks. When the cycle is finished, the block answers with a one-clock acknowledge. On a read, the byte taken from the flash bus comes back with that acknowledge.

A small write-only register port sets the block up. It loads the three phase counts, a global enable, the chip-enable levels and the ready/busy detector settings, and it clears the detect flag. The ready/busy input is synchronised and watched for one chosen transition. That transition sets a sticky flag, and the flag can raise an interrupt when the interrupt is enabled.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, CLE and ALE are low, both strobes are high, the bus is not driven, the acknowledge is low, every chip-enable output is high, and the ready/busy flag and interrupt are low.
- R2: A command cycle (kind code 0) holds CLE high through the setup, strobe and hold phases, while ALE stays low.
- R3: An address cycle (kind code 1) holds ALE high over the same window, while CLE stays low. Data cycles (kind 2 = write, kind 3 = read) keep both low. CLE and ALE are never high together.
- R4: The register select codes are: 0 = timing, 1 = control, 2 = status. The timing register holds the setup count in bits [2:0], the strobe count in bits [5:3] and the hold count in bits [8:6]. When the setup count S is not zero, exactly S cycles pass between the cycle in which a request is accepted and the first strobe-low cycle.
- R5: The strobe stays low for (strobe count + 1) cycles. Kinds 0 to 2 drive the write strobe low; kind 3 drives the read strobe low. Both strobes are never low together.
- R6: After the strobe rises, the hold phase lasts (hold count + 1) cycles. Then the acknowledge is high for exactly one cycle, with CLE and ALE low, both strobes high and the bus released.
- R7: With a setup count of 0, the strobe goes low in the first cycle after the request is accepted.
- R8: Kinds 0 to 2 drive the request byte onto the bus from the start of setup to the end of hold. A read never drives the bus.
- R9: A read samples the flash bus on the clock edge at which the read strobe returns high, and presents that byte on ack_data while the acknowledge is high.
- R10: While the enable bit (control bit 0) is 0, requests are ignored: no strobe falls and no acknowledge appears.
- R11: Control bit 3 selects the detected ready/busy edge: 0 means low-to-high, 1 means high-to-low. Only the selected transition of the synchronised input sets the flag.
- R12: The flag stays set until a status write with bit 0 = 1 clears it; a status write with bit 0 = 0 leaves it set. The interrupt equals the flag ANDed with the interrupt-enable bit (control bit 4).
- R13: Control bits [2:1] drive the two chip-enable outputs directly, with 0 meaning asserted low. A new value appears in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 timing, 1 control, 2 status |
| cfg_wdata | input | 9 | Register write data |
| req_valid | input | 1 | Cycle request, held until acknowledged |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte to drive for kinds 0 to 2 |
| req_ack | output | 1 | One-cycle completion pulse |
| ack_data | output | 8 | Byte captured by the last read |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Bus output value |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | 8 | Bus input value |
| rb_in | input | 1 | Ready/busy pin from the flash |
| nand_ce_n | output | 2 | Chip enables, active low |
| rb_flag | output | 1 | Sticky ready/busy transition flag |
| rb_irq | output | 1 | Ready/busy interrupt |

## Verification
The bench uses the default parameters: 3-bit phase fields, two chip enables and a two-stage ready/busy synchroniser. With 3-bit fields, both extremes of every phase count can be reached in a few dozen clocks, so runs with all counts at 0 and with all counts at 7 sit next to mixed settings. The read cases put a new byte on the flash bus in every clock, which shows whether the byte is taken on the exact edge at which the read strobe rises. With two synchroniser stages the detect latency is fixed and short, so the reference model can follow the flag and the interrupt in every cycle while both edge selections are exercised.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

   typedef enum logic [1:0] {
      OP_CMD   = 2'd0,
      OP_ADDR  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_DONE
   } phase_e;

   localparam logic [1:0] SEL_TIMING = 2'd0;
   localparam logic [1:0] SEL_CTRL   = 2'd1;
   localparam logic [1:0] SEL_STATUS = 2'd2;

endpackage

// File: rtl/nand_cyc_cfg.sv
module nand_cyc_cfg
   import nand_cyc_pkg::*;
#(
   parameter int CNT_W  = 3,
   parameter int NUM_CE = 2,
   parameter int CFG_W  = 3 * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CNT_W-1:0]  t_setup,
   output logic [CNT_W-1:0]  t_strobe,
   output logic [CNT_W-1:0]  t_hold,
   output logic              ctl_en,
   output logic [NUM_CE-1:0] ce_lvl,
   output logic              fall_sel,
   output logic              irq_en,
   output logic              flag_clr
);

   localparam int CE_LO   = 1;
   localparam int FALL_B  = NUM_CE + 1;
   localparam int IEN_B   = NUM_CE + 2;

   wire wr_timing = cfg_wr && (cfg_sel == SEL_TIMING);
   wire wr_ctrl   = cfg_wr && (cfg_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_setup  <= '0;
         t_strobe <= '0;
         t_hold   <= '0;
         ctl_en   <= 1'b0;
         ce_lvl   <= '1;
         fall_sel <= 1'b0;
         irq_en   <= 1'b0;
      end else begin
         if (wr_timing) begin
            t_setup  <= cfg_wdata[CNT_W-1:0];
            t_strobe <= cfg_wdata[2*CNT_W-1:CNT_W];
            t_hold   <= cfg_wdata[3*CNT_W-1:2*CNT_W];
         end
         if (wr_ctrl) begin
            ctl_en   <= cfg_wdata[0];
            ce_lvl   <= cfg_wdata[CE_LO +: NUM_CE];
            fall_sel <= cfg_wdata[FALL_B];
            irq_en   <= cfg_wdata[IEN_B];
         end
      end
   end

   assign flag_clr = cfg_wr && (cfg_sel == SEL_STATUS) && cfg_wdata[0];

endmodule

// File: rtl/nand_cyc_rb.sv
module nand_cyc_rb #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_in,
   input  logic fall_sel,
   input  logic flag_clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   rb_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rb_in};
         last_q <= rb_s;
      end
   end

   assign rb_s = sync_q[SYNC_STAGES-1];

   wire hit = fall_sel ? (last_q && !rb_s) : (!last_q && rb_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag && !flag_clr) || hit;
   end

   assign irq = flag && irq_en;

endmodule

// File: rtl/nand_cyc_seq.sv
module nand_cyc_seq
   import nand_cyc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CNT_W-1:0]  t_setup,
   input  logic [CNT_W-1:0]  t_strobe,
   input  logic [CNT_W-1:0]  t_hold,
   input  logic              req_valid,
   input  op_e               req_kind,
   input  logic [DATA_W-1:0] req_data,
   input  logic [DATA_W-1:0] dq_in,
   output logic              req_ack,
   output logic [DATA_W-1:0] ack_data,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_e            ph;
   op_e               op;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] wbuf;
   logic [DATA_W-1:0] rbuf;

   wire last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         op   <= OP_CMD;
         cnt  <= '0;
         wbuf <= '0;
         rbuf <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (en && req_valid) begin
               op   <= req_kind;
               wbuf <= req_data;
               if (t_setup != '0) begin
                  ph  <= PH_SETUP;
                  cnt <= t_setup - ONE;
               end else begin
                  ph  <= PH_STROBE;
                  cnt <= t_strobe;
               end
            end
            PH_SETUP: if (last) begin
               ph  <= PH_STROBE;
               cnt <= t_strobe;
            end else cnt <= cnt - ONE;
            PH_STROBE: if (last) begin
               ph  <= PH_HOLD;
               cnt <= t_hold;
               if (op == OP_READ) rbuf <= dq_in;
            end else cnt <= cnt - ONE;
            PH_HOLD: if (last) ph <= PH_DONE;
                     else      cnt <= cnt - ONE;
            PH_DONE: ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   wire busy   = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
   wire is_rd  = (op == OP_READ);

   assign cle      = busy && (op == OP_CMD);
   assign ale      = busy && (op == OP_ADDR);
   assign we_n     = !((ph == PH_STROBE) && !is_rd);
   assign re_n     = !((ph == PH_STROBE) && is_rd);
   assign dq_oe    = busy && !is_rd;
   assign dq_out   = wbuf;
   assign req_ack  = (ph == PH_DONE);
   assign ack_data = rbuf;

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
   import nand_cyc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 3,
   parameter int NUM_CE      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_W       = 3 * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ack,
   output logic [DATA_W-1:0] ack_data,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              rb_in,
   output logic [NUM_CE-1:0] nand_ce_n,
   output logic              rb_flag,
   output logic              rb_irq
);

   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_CE < 1 || NUM_CE + 3 > CFG_W) begin : g_bad_ce
      $error("NUM_CE does not fit the control register");
   end
   if (CFG_W != 3 * CNT_W) begin : g_bad_cfg
      $error("CFG_W must equal three timing fields");
   end

   logic [CNT_W-1:0]  t_setup, t_strobe, t_hold;
   logic              ctl_en, fall_sel, irq_en, flag_clr;
   logic [NUM_CE-1:0] ce_lvl;

   nand_cyc_cfg #(.CNT_W(CNT_W), .NUM_CE(NUM_CE), .CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .t_setup(t_setup), .t_strobe(t_strobe),
      .t_hold(t_hold), .ctl_en(ctl_en), .ce_lvl(ce_lvl),
      .fall_sel(fall_sel), .irq_en(irq_en), .flag_clr(flag_clr)
   );

   nand_cyc_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(ctl_en), .t_setup(t_setup),
      .t_strobe(t_strobe), .t_hold(t_hold), .req_valid(req_valid),
      .req_kind(op_e'(req_kind)), .req_data(req_data), .dq_in(dq_in),
      .req_ack(req_ack), .ack_data(ack_data), .cle(nand_cle),
      .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   nand_cyc_rb #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
      .clk(clk), .rst_n(rst_n), .rb_in(rb_in), .fall_sel(fall_sel),
      .flag_clr(flag_clr), .irq_en(irq_en), .flag(rb_flag), .irq(rb_irq)
   );

   for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
      assign nand_ce_n[i] = ce_lvl[i];
   end

endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk #(
   parameter int NUM_CE = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cle,
   input logic              ale,
   input logic              we_n,
   input logic              re_n,
   input logic              dq_oe,
   input logic              req_ack,
   input logic              rb_flag,
   input logic              rb_irq,
   input logic              cfg_wr,
   input logic [1:0]        cfg_sel,
   input logic              clr_bit,
   input logic [NUM_CE-1:0] ce_bits,
   input logic [NUM_CE-1:0] ce_n
);

   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R3
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R5
   AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe); // R8
   AST_DATA_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) (!we_n && !cle && !ale) |-> dq_oe); // R8
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack); // R6
   AST_ACK_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> (we_n && re_n && !dq_oe && !cle && !ale)); // R6
   AST_HOLD_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> !req_ack); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rb_flag && !(cfg_wr && cfg_sel == 2'd2 && clr_bit)) |=> rb_flag); // R12
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rb_irq |-> rb_flag); // R12
   AST_CE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && cfg_sel == 2'd1) |=> (ce_n == $past(ce_bits))); // R13

endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(.NUM_CE(NUM_CE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cle(nand_cle), .ale(nand_ale),
   .we_n(nand_we_n), .re_n(nand_re_n), .dq_oe(dq_oe), .req_ack(req_ack),
   .rb_flag(rb_flag), .rb_irq(rb_irq), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
   .clr_bit(cfg_wdata[0]), .ce_bits(cfg_wdata[NUM_CE:1]), .ce_n(nand_ce_n)
);

// File: tb/sim_nand_cycle_gen.sv
module sim_nand_cycle_gen;

   localparam int CNT_W  = 3;
   localparam int NUM_CE = 2;
   localparam int CFG_W  = 3 * CNT_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              cfg_wr = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_kind = 2'd0;
   logic [7:0]        req_data = 8'h00;
   logic [7:0]        dq_in = 8'h5A;
   logic              rb_in = 1'b1;
   logic              req_ack, cle, ale, we_n, re_n, dq_oe, rb_flag, rb_irq;
   logic [7:0]        ack_data, dq_out;
   logic [NUM_CE-1:0] ce_n;

   nand_cycle_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_kind(req_kind),
      .req_data(req_data), .req_ack(req_ack), .ack_data(ack_data),
      .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
      .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_in(rb_in),
      .nand_ce_n(ce_n), .rb_flag(rb_flag), .rb_irq(rb_irq)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: phase number, cycles left, latched request, registers
   int         m_ph, m_left, m_kind, m_tas, m_tw0, m_tw1;
   logic [7:0] m_wd, m_rd;
   bit         m_en, m_fall, m_ien, m_flag, m_s1, m_s2, m_prev;
   logic [NUM_CE-1:0] m_ce;

   always @(posedge clk) begin
      bit det;
      bit clr;
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_kind = 0; m_tas = 0; m_tw0 = 0; m_tw1 = 0;
         m_wd = 8'h00; m_rd = 8'h00; m_en = 0; m_fall = 0; m_ien = 0;
         m_flag = 0; m_s1 = 1; m_s2 = 1; m_prev = 1; m_ce = '1;
      end else begin
         case (m_ph)
            0: if (m_en && req_valid) begin
                  m_kind = int'(req_kind); m_wd = req_data;
                  if (m_tas > 0) begin m_ph = 1; m_left = m_tas; end
                  else begin m_ph = 2; m_left = m_tw0 + 1; end
               end
            1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = m_tw0 + 1; end end
            2: begin
                  m_left--;
                  if (m_left == 0) begin
                     m_ph = 3; m_left = m_tw1 + 1;
                     if (m_kind == 3) m_rd = dq_in;
                  end
               end
            3: begin m_left--; if (m_left == 0) m_ph = 4; end
            default: m_ph = 0;
         endcase
         det = m_fall ? (m_prev && !m_s2) : (!m_prev && m_s2);
         clr = cfg_wr && cfg_sel == 2'd2 && cfg_wdata[0];
         m_flag = (m_flag && !clr) || det;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = rb_in;
         if (cfg_wr && cfg_sel == 2'd0) begin
            m_tas = int'(cfg_wdata[2:0]); m_tw0 = int'(cfg_wdata[5:3]); m_tw1 = int'(cfg_wdata[8:6]);
         end
         if (cfg_wr && cfg_sel == 2'd1) begin
            m_en = cfg_wdata[0]; m_ce = cfg_wdata[2:1]; m_fall = cfg_wdata[3]; m_ien = cfg_wdata[4];
         end
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      bit busy;
      if (rst_n) begin
         busy = (m_ph >= 1 && m_ph <= 3);
         chk("R2", "cle", cle, busy && m_kind == 0);
         chk("R3", "ale", ale, busy && m_kind == 1);
         chk("R5", "we_n", we_n, !(m_ph == 2 && m_kind != 3));
         chk("R5", "re_n", re_n, !(m_ph == 2 && m_kind == 3));
         chk("R8", "dq_oe", dq_oe, busy && m_kind != 3);
         if (busy && m_kind != 3) chk("R8", "dq_out", dq_out, m_wd);
         chk("R6", "req_ack", req_ack, m_ph == 4);
         if (m_ph == 4 && m_kind == 3) chk("R9", "ack_data", ack_data, m_rd);
         chk("R13", "ce_n", ce_n, m_ce);
         chk("R11", "rb_flag", rb_flag, m_flag);
         chk("R12", "rb_irq", rb_irq, m_flag && m_ien);
      end
   end

   task automatic wcfg(input logic [1:0] sel, input logic [CFG_W-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_timing(input int ts, input int t0, input int t1);
      wcfg(2'd0, {3'(t1), 3'(t0), 3'(ts)});
   endtask

   task automatic issue(input logic [1:0] k, input logic [7:0] d, input int lim,
                        output bit acked, output int pre, output int low,
                        output int hold, output int oe_n, output logic [7:0] cap);
      bit seen = 0;
      acked = 0; pre = 0; low = 0; hold = 0; oe_n = 0; cap = 8'h00;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_data = d;
      for (int g = 0; g < lim; g++) begin
         @(negedge clk);
         if (req_ack) begin acked = 1; break; end
         if (dq_oe) oe_n++;
         if (!we_n || !re_n) begin low++; seen = 1; end
         else if (seen) hold++;
         else pre++;
         dq_in = dq_in * 8'd5 + 8'd3;
         if (!re_n) cap = dq_in;
      end
      req_valid = 1'b0;
   endtask

   task automatic timed(input logic [1:0] k, input logic [7:0] d, input int ts, input int t0, input int t1);
      bit a; int p, l, h, o; logic [7:0] c;
      issue(k, d, 100, a, p, l, h, o, c);
      chk("R6", "ack seen", a, 1);
      if (ts == 0) chk("R7", "setup cycles", p, 0);
      else         chk("R4", "setup cycles", p, ts);
      chk("R5", "strobe cycles", l, t0 + 1);
      chk("R6", "hold cycles", h, t1 + 1);
      chk("R8", "bus drive cycles", o, (k == 2'd3) ? 0 : ts + t0 + t1 + 2);
      if (k == 2'd3) chk("R9", "read capture", ack_data, c);
   endtask

   initial begin
      bit a; int p, l, h, o; logic [7:0] c;
      repeat (3) @(negedge clk);
      chk("R1", "cle in reset", cle, 0);
      chk("R1", "ale in reset", ale, 0);
      chk("R1", "strobes in reset", {we_n, re_n}, 2'b11);
      chk("R1", "bus in reset", dq_oe, 0);
      chk("R1", "ack in reset", req_ack, 0);
      chk("R1", "ce_n in reset", ce_n, 2'b11);
      chk("R1", "flag/irq in reset", {rb_flag, rb_irq}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);

      issue(2'd0, 8'hFF, 20, a, p, l, h, o, c);
      chk("R10", "ack while disabled", a, 0);
      chk("R10", "strobe while disabled", l, 0);

      wcfg(2'd1, 9'h007);
      set_timing(2, 3, 1); timed(2'd0, 8'h70, 2, 3, 1);
      set_timing(0, 0, 0); timed(2'd1, 8'h12, 0, 0, 0);
      timed(2'd2, 8'h99, 0, 0, 0);
      set_timing(7, 7, 7); timed(2'd2, 8'hA5, 7, 7, 7);
      timed(2'd3, 8'h00, 7, 7, 7);
      set_timing(1, 2, 0); timed(2'd3, 8'h00, 1, 2, 0);
      set_timing(0, 4, 2); timed(2'd3, 8'h00, 0, 4, 2);
      timed(2'd2, 8'h3C, 0, 4, 2);
      timed(2'd1, 8'hC3, 0, 4, 2);

      wcfg(2'd1, 9'h003); chk("R13", "ce_n after 01", ce_n, 2'b01);
      wcfg(2'd1, 9'h005); chk("R13", "ce_n after 10", ce_n, 2'b10);
      wcfg(2'd1, 9'h007);

      rb_in = 1'b0; repeat (5) @(negedge clk);
      chk("R11", "falling ignored with rising select", rb_flag, 0);
      rb_in = 1'b1; repeat (5) @(negedge clk);
      chk("R11", "rising sets flag", rb_flag, 1);
      chk("R12", "irq gated off", rb_irq, 0);
      wcfg(2'd1, 9'h017);
      chk("R12", "irq when enabled", rb_irq, 1);
      wcfg(2'd2, 9'h000);
      chk("R12", "write 0 keeps flag", rb_flag, 1);
      wcfg(2'd2, 9'h001);
      chk("R12", "write 1 clears flag", rb_flag, 0);
      chk("R12", "irq drops with flag", rb_irq, 0);

      wcfg(2'd1, 9'h01F);
      rb_in = 1'b0; repeat (5) @(negedge clk);
      chk("R11", "falling sets flag", rb_flag, 1);
      wcfg(2'd2, 9'h001);
      rb_in = 1'b1; repeat (5) @(negedge clk);
      chk("R11", "rising ignored with falling select", rb_flag, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule